// File: doc/BRIEF.md
# Upset-Tolerant Serial Key Detector

This block watches a one-bit serial stream and raises a one-cycle `hit` pulse each time the most recent sixteen accepted bits equal a fixed key. It is a prefix-tracking state machine with one state for each matched prefix length, zero to fifteen. A mismatch falls back to the longest prefix that is still valid, so key occurrences that overlap are all reported.

The state register is protected against single-event upsets. In the delivered configuration each of the sixteen states is stored as a seven-bit single-error-correcting word. Any two words are at least three bit flips apart. Every register value is decoded to the state whose word lies within one flip of it, so a single upset leaves the sequence of `hit` pulses unchanged. On every clock the register is rewritten with the clean word of the next state, which scrubs an upset before a second one can add to it. A parameter also selects plain binary, one-hot or parity-extended binary codes. Those codes detect a bad value at best, and any value they do not recognise sends the machine back to idle.

Serial bits arrive on a valid/ready pair. `s_ready` is held high at all times, so the source never sees back-pressure, and a bit is taken on every cycle with `s_valid` high. `flip_mask` is XORed into the value written to the state register. It exists to inject faults and is held at zero in normal use.

Top module: `keyword_sentinel`

## Requirements
- R1: After the synchronous reset is released, `hit` is low and the machine is in the empty-prefix state, so the next key is counted from its first bit.
- R2: The key is received most significant bit first: KEY[15] first, KEY[0] last. `hit` is high for exactly one cycle, the cycle after the accepted beat that carries KEY[0], when the fifteen accepted bits before that beat equal KEY[15:1].
- R3: Overlapping occurrences are reported. With the default key 16'hA5A5, the stream A5 A5 A5 gives one pulse after bit 16 and another after bit 24.
- R4: A cycle with `s_valid` low leaves the matched prefix unchanged whatever `s_bit` holds, and `hit` is low in the cycle after it.
- R5: `s_ready` is high in every cycle after reset, so a bit is accepted in every cycle where `s_valid` is high.
- R6: In the seven-bit state code, a `flip_mask` value with exactly one bit set, in any position 0 to 6, applied together with any accepted beat leaves every `hit` pulse unchanged.
- R7: `flip_mask` affects only the value captured in its own cycle. The register is rewritten with a clean code on every clock, including cycles with no beat, so single flips on consecutive cycles never add up.
- R8: The synchronous reset takes priority over a beat and over `flip_mask`, and it discards any partly matched prefix.
- R9: A sixteen-bit sequence that differs from the key in one bit produces no pulse. The next complete key is still detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Serial bit valid |
| s_ready | output | 1 | Always high: bit accepted whenever valid |
| s_bit | input | 1 | Serial data bit |
| flip_mask | input | SW (7 by default) | Fault injection, XORed into the captured state code |
| hit | output | 1 | One-cycle key match pulse |

## Verification
An injected upset can land in the same cycle as the beat that carries the final key bit. The detection decision and the corrupted capture then meet on one clock edge. The stimulus table applies a single-bit flip at a rotating position on every beat of several key transmissions, final beat included. A directed sweep repeats this for each of the seven bit positions. The outcome is judged by requiring `hit` exactly in the cycle after the final beat and nowhere else. A further test applies flips during idle cycles just before the final bit, to show that holding the state also scrubs it.

// File: rtl/kw_pkg.sv
`timescale 1ns/1ps
package kw_pkg;

  typedef enum logic [1:0] {
    CODE_BIN    = 2'd0,
    CODE_ONEHOT = 2'd1,
    CODE_PAR    = 2'd2,
    CODE_SEC    = 2'd3
  } code_style_e;

  localparam int CODE_MAX = 64;

  function automatic int idx_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // check bits needed for single-error correction of d data bits
  function automatic int sec_checks(input int d);
    int r;
    r = 0;
    while ((1 << r) < d + r + 1) r++;
    return r;
  endfunction

  function automatic int code_width(input code_style_e s, input int n);
    case (s)
      CODE_BIN:    return idx_bits(n);
      CODE_ONEHOT: return n;
      CODE_PAR:    return idx_bits(n) + 1;
      default:     return idx_bits(n) + sec_checks(idx_bits(n));
    endcase
  endfunction

  // how many flipped bits a stored code may carry and still decode
  function automatic int code_slack(input code_style_e s);
    return (s == CODE_SEC) ? 1 : 0;
  endfunction

  // code word for state number idx
  function automatic logic [CODE_MAX-1:0] code_word(input code_style_e s, input int n, input int idx);
    logic [CODE_MAX-1:0] w;
    int d;
    int r;
    int k;
    logic par;
    w = '0;
    d = idx_bits(n);
    case (s)
      CODE_BIN: w = CODE_MAX'(idx);
      CODE_ONEHOT: w[idx] = 1'b1;
      CODE_PAR: begin
        w = CODE_MAX'(idx);
        par = 1'b0;
        for (int j = 0; j < d; j++) par = par ^ w[j];
        w[d] = par;
      end
      default: begin
        r = sec_checks(d);
        k = 0;
        // data bits sit at the positions that are not powers of two
        for (int p = 1; p <= d + r; p++) begin
          if ((p & (p - 1)) != 0) begin
            w[p-1] = idx[k];
            k++;
          end
        end
        for (int j = 0; j < r; j++) begin
          par = 1'b0;
          for (int p = 1; p <= d + r; p++) begin
            if ((((p >> j) & 1) == 1) && ((p & (p - 1)) != 0)) par = par ^ w[p-1];
          end
          w[(1 << j) - 1] = par;
        end
      end
    endcase
    return w;
  endfunction

  // longest key prefix that ends the stream "prefix(len) followed by b",
  // limited to n-1 so that a full match falls back to its longest border
  function automatic int prefix_after(input logic [CODE_MAX-1:0] key, input int n,
                                      input int len, input logic b);
    int res;
    int pos;
    logic ok;
    logic sb;
    res = 0;
    for (int k = 1; k < n; k++) begin
      if (k <= len + 1) begin
        ok = 1'b1;
        for (int i = 0; i < k; i++) begin
          pos = len + 1 - k + i;
          sb = (pos == len) ? b : key[n-1-pos];
          if (sb != key[n-1-i]) ok = 1'b0;
        end
        if (ok) res = k;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/kw_code_map.sv
`timescale 1ns/1ps
// Translates between state numbers and stored state codes.
module kw_code_map #(
  parameter kw_pkg::code_style_e STYLE = kw_pkg::CODE_SEC,
  parameter int N  = 16,
  parameter int SW = kw_pkg::code_width(STYLE, N),
  parameter int IW = kw_pkg::idx_bits(N)
) (
  input  logic [SW-1:0] code_q,
  input  logic [IW-1:0] nxt_idx,
  output logic [IW-1:0] cur_idx,
  output logic [SW-1:0] nxt_code
);
  localparam int SLACK = kw_pkg::code_slack(STYLE);

  logic [SW-1:0] words [N];
  logic [N-1:0]  near;

  for (genvar i = 0; i < N; i++) begin : g_word
    localparam logic [SW-1:0] CW = SW'(kw_pkg::code_word(STYLE, N, i));
    assign words[i] = CW;
    // a stored value belongs to state i if it is within SLACK flips of its word
    assign near[i]  = ($countones(code_q ^ CW) <= SLACK);
  end

  // a value that belongs to no state falls back to idle (state 0)
  always_comb begin
    cur_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (near[i]) cur_idx = IW'(i);
    end
  end

  assign nxt_code = words[nxt_idx];

endmodule

// File: rtl/kw_prefix_step.sv
`timescale 1ns/1ps
// Prefix-tracking transition logic; the table is computed from KEY at elaboration.
module kw_prefix_step #(
  parameter int N = 16,
  parameter logic [N-1:0] KEY = 16'hA5A5,
  parameter int IW = kw_pkg::idx_bits(N)
) (
  input  logic [IW-1:0] cur_idx,
  input  logic          take,
  input  logic          bit_in,
  output logic [IW-1:0] nxt_idx,
  output logic          last_hit
);
  localparam logic [kw_pkg::CODE_MAX-1:0] KEY_W = 64'(KEY);

  logic [IW-1:0] go0 [N];
  logic [IW-1:0] go1 [N];

  for (genvar s = 0; s < N; s++) begin : g_row
    localparam int ON0 = kw_pkg::prefix_after(KEY_W, N, s, 1'b0);
    localparam int ON1 = kw_pkg::prefix_after(KEY_W, N, s, 1'b1);
    assign go0[s] = IW'(ON0);
    assign go1[s] = IW'(ON1);
  end

  always_comb begin
    if (take) nxt_idx = bit_in ? go1[cur_idx] : go0[cur_idx];
    else      nxt_idx = cur_idx;
  end

  assign last_hit = take && (cur_idx == IW'(N - 1)) && (bit_in == KEY[0]);

endmodule

// File: rtl/keyword_sentinel.sv
`timescale 1ns/1ps
module keyword_sentinel #(
  parameter int KEY_BITS = 16,
  parameter logic [KEY_BITS-1:0] KEY = 16'hA5A5,
  parameter kw_pkg::code_style_e STYLE = kw_pkg::CODE_SEC,
  parameter int SW = kw_pkg::code_width(STYLE, KEY_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic          s_bit,
  input  logic [SW-1:0] flip_mask,
  output logic          hit
);
  localparam int IW = kw_pkg::idx_bits(KEY_BITS);
  localparam logic [SW-1:0] IDLE_CODE = SW'(kw_pkg::code_word(STYLE, KEY_BITS, 0));

  logic [SW-1:0] state_q;
  logic [SW-1:0] nxt_code;
  logic [IW-1:0] cur_idx;
  logic [IW-1:0] nxt_idx;
  logic          take;
  logic          last_hit;

  assign s_ready = 1'b1;
  assign take    = s_valid & s_ready;

  kw_code_map #(
    .STYLE (STYLE),
    .N     (KEY_BITS),
    .SW    (SW),
    .IW    (IW)
  ) u_map (
    .code_q   (state_q),
    .nxt_idx  (nxt_idx),
    .cur_idx  (cur_idx),
    .nxt_code (nxt_code)
  );

  kw_prefix_step #(
    .N   (KEY_BITS),
    .KEY (KEY),
    .IW  (IW)
  ) u_step (
    .cur_idx  (cur_idx),
    .take     (take),
    .bit_in   (s_bit),
    .nxt_idx  (nxt_idx),
    .last_hit (last_hit)
  );

  // every clock rewrites a clean code, which scrubs any earlier upset
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= IDLE_CODE;
      hit     <= 1'b0;
    end else begin
      state_q <= nxt_code ^ flip_mask;
      hit     <= last_hit;
    end
  end

endmodule

// File: rtl/keyword_sentinel_chk.sv
`timescale 1ns/1ps
module keyword_sentinel_chk #(
  parameter int KEY_BITS = 16,
  parameter logic [KEY_BITS-1:0] KEY = 16'hA5A5,
  parameter kw_pkg::code_style_e STYLE = kw_pkg::CODE_SEC,
  parameter int SW = 7,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          s_valid,
  input logic          s_bit,
  input logic [SW-1:0] flip_mask,
  input logic          hit,
  input logic [IW-1:0] cur_idx,
  input logic [IW-1:0] nxt_idx
);

  p_reset_quiet_r8: assert property (@(posedge clk) rst |=> !hit);

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (cur_idx == '0));

  p_hit_needs_beat_r4: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(s_valid));

  p_hit_last_bit_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(s_bit) == KEY[0]));

  p_hit_full_prefix_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(cur_idx) == IW'(KEY_BITS - 1)));

  p_idle_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (!s_valid && (flip_mask == '0)) |=> (cur_idx == $past(cur_idx)));

  if (STYLE == kw_pkg::CODE_SEC) begin : g_sec
    p_flip_absorbed_r6: assert property (@(posedge clk) disable iff (rst)
      ($countones(flip_mask) <= 1) |=> (cur_idx == $past(nxt_idx)));

    p_idle_scrub_r7: assert property (@(posedge clk) disable iff (rst)
      (!s_valid && ($countones(flip_mask) <= 1)) |=> (cur_idx == $past(cur_idx)));
  end

endmodule

bind keyword_sentinel keyword_sentinel_chk #(
  .KEY_BITS (KEY_BITS),
  .KEY      (KEY),
  .STYLE    (STYLE),
  .SW       (SW),
  .IW       (IW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .s_valid   (s_valid),
  .s_bit     (s_bit),
  .flip_mask (flip_mask),
  .hit       (hit),
  .cur_idx   (cur_idx),
  .nxt_idx   (nxt_idx)
);

// File: tb/keyword_sentinel_bench.sv
`timescale 1ns/1ps
module keyword_sentinel_bench;
  import kw_pkg::*;

  localparam int KEY_BITS = 16;
  localparam logic [KEY_BITS-1:0] KEY = 16'hA5A5;
  localparam int SW = code_width(CODE_SEC, KEY_BITS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0;
  logic s_bit = 1'b0;
  logic s_ready;
  logic hit;
  logic [SW-1:0] flip_mask = '0;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  keyword_sentinel #(
    .KEY_BITS (KEY_BITS),
    .KEY      (KEY),
    .STYLE    (CODE_SEC),
    .SW       (SW)
  ) u_keyword_sentinel (
    .clk       (clk),
    .rst       (rst),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_bit     (s_bit),
    .flip_mask (flip_mask),
    .hit       (hit)
  );

  // byte rows, bits sent MSB first; gaps bit i = idle cycle before bit i;
  // flip = {enable, start position}; exp bit i = hit after bit i
  typedef struct packed {
    logic [7:0] data;
    logic [7:0] gaps;
    logic [3:0] flip;
    logic [7:0] exp;
  } row_t;

  localparam int NROWS = 13;
  localparam row_t ROWS [NROWS] = '{
    '{8'hA5, 8'h00, 4'h0, 8'h00},
    '{8'hA5, 8'h00, 4'h0, 8'h80},
    '{8'hA5, 8'h00, 4'h0, 8'h80},
    '{8'hA5, 8'h55, 4'h8, 8'h80},
    '{8'h00, 8'h00, 4'h0, 8'h00},
    '{8'hA5, 8'h00, 4'h0, 8'h00},
    '{8'hA4, 8'h00, 4'h0, 8'h00},
    '{8'hA5, 8'h00, 4'h9, 8'h00},
    '{8'hA5, 8'hAA, 4'hD, 8'h80},
    '{8'h00, 8'h00, 4'h0, 8'h00},
    '{8'h25, 8'h00, 4'h0, 8'h00},
    '{8'hA5, 8'h00, 4'hE, 8'h00},
    '{8'hA5, 8'h0F, 4'hB, 8'h80}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic beat(input logic v, input logic b, input logic [SW-1:0] m,
                      input logic exp, input string tag);
    s_valid   = v;
    s_bit     = b;
    flip_mask = m;
    @(posedge clk);
    @(negedge clk);
    check(tag, hit, exp);
    s_valid   = 1'b0;
    flip_mask = '0;
  endtask

  task automatic send_byte(input logic [7:0] data, input logic [7:0] gaps,
                           input logic [3:0] flip, input logic [7:0] exp, input string tag);
    logic [SW-1:0] m;
    check({tag, " R5 ready"}, s_ready, 1'b1);
    for (int i = 0; i < 8; i++) begin
      if (gaps[i]) beat(1'b0, ~data[7-i], '0, 1'b0, {tag, " R4 idle"});
      m = flip[3] ? (SW'(1) << ((int'(flip[2:0]) + i) % SW)) : '0;
      beat(1'b1, data[7-i], m, exp[i], tag);
    end
  endtask

  task automatic send_key_head(input string tag);
    for (int i = 0; i < KEY_BITS - 1; i++) beat(1'b1, KEY[KEY_BITS-1-i], '0, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 hit low after reset", hit, 1'b0);
    check("R5 ready after reset", s_ready, 1'b1);

    // table walk: R2 detection, R3 overlap, R4 gaps, R6 flips, R9 near misses
    for (int r = 0; r < NROWS; r++) begin
      send_byte(ROWS[r].data, ROWS[r].gaps, ROWS[r].flip, ROWS[r].exp,
                $sformatf("R2/R3/R6/R9 row %0d", r));
    end

    // R2: pulse lasts one cycle
    beat(1'b0, 1'b1, '0, 1'b0, "R2 single-cycle pulse");

    // R6: single flip in every position on every beat of a whole key
    for (int p = 0; p < SW; p++) begin
      send_byte(8'h00, 8'h00, 4'h0, 8'h00, "R6 clear");
      send_byte(KEY[15:8], 8'h00, {1'b1, 3'(p)}, 8'h00, $sformatf("R6 pos %0d high byte", p));
      send_byte(KEY[7:0], 8'h00, {1'b1, 3'(p)}, 8'h80, $sformatf("R6 pos %0d low byte", p));
    end

    // R7: upsets on consecutive idle cycles before the final bit
    send_byte(8'h00, 8'h00, 4'h0, 8'h00, "R7 clear");
    send_key_head("R7 head");
    for (int p = 0; p < 5; p++) beat(1'b0, 1'b0, SW'(1) << p, 1'b0, "R7 idle flip");
    beat(1'b1, KEY[0], '0, 1'b1, "R7 hit after idle flips");

    // R8: reset mid-prefix beats a final bit and an all-ones mask
    send_byte(8'h00, 8'h00, 4'h0, 8'h00, "R8 clear");
    send_key_head("R8 head");
    rst = 1'b1;
    beat(1'b1, KEY[0], '1, 1'b0, "R8 beat under reset");
    rst = 1'b1;
    beat(1'b1, KEY[0], '1, 1'b0, "R8 reset held");
    rst = 1'b0;
    beat(1'b1, KEY[0], '0, 1'b0, "R8 prefix discarded");
    send_byte(KEY[15:8], 8'h00, 4'h0, 8'h00, "R8 relearn high");
    send_byte(KEY[7:0], 8'h00, 4'h0, 8'h80, "R8 relearn low");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule